// File: doc/BRIEF.md
# Complementary Pair PWM Timer

This block produces pulse-width-modulated waveforms on channel pairs that all share one period counter. A selectable prescaler paces the counter, which runs in one of two shapes: a down-count from the period value to zero (edge-aligned) or an up-then-down triangle between zero and the period value (center-aligned). Each pair has one compare value. The even and odd channel of a pair either carry the same waveform, or they carry opposite waveforms with a programmable dead-time that delays every rising edge.

Software sets the block up through a single-cycle write port. The period and compare values are written into staging registers. They reach the counter only after a load request, at the next period boundary, so a cycle already under way is never cut short. A period flag and one duty flag per pair record counter events. The flags stay set until software clears them, and a single interrupt line carries the enabled flags.

Top module: `pwm_cmpl_timer`

## Requirements
- R1: The prescaler code in control bits [2:1] sets the number of clock cycles per counter step: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 16. Control bit 0 enables counting.
- R2: When control bit 3 is 0 (edge-aligned), the counter steps down to 0. The step after 0 reloads the period value, so one period lasts period+1 steps.
- R3: When control bit 3 is 1 (center-aligned), the counter steps up from 0 to the period value, then down to 0, so one period lasts 2*period steps.
- R4: Writes to the period (address 1) and compare k (address 2+k) go into staging registers and have no effect until control bit 8 is written as 1. The staged values then take effect at the next step that leaves counter value 0 at the bottom of a period.
- R5: While the active period value is 0, the counter stays halted at 0 and raises no events. A pending load then takes effect on the next prescaler step.
- R6: Each pair's base waveform is registered one cycle behind the counter. In edge-aligned mode it is high while counter > compare. In center-aligned mode it is high while counter <= compare.
- R7: Channels 2k and 2k+1 use compare k. Mode codes 0, 2 and 3 in control bits [6:5] drive both channels of a pair with the same base waveform, with no delay added.
- R8: Mode code 1 drives the odd channel with the inverse of the base waveform. For each channel, the output rises only after its source has been high for more than D clock cycles, where D is written at address 5. A pair's two outputs are never high together.
- R9: Control bit 7 inverts every channel. A channel whose bit is 0 in the output-enable register (address 6) drives 0. After reset, all outputs and flags are 0.
- R10: Control bit 4 selects where the period flag (flag bit 0) is set: 0 sets it on the step that leaves counter value 0 at the bottom, 1 sets it on the step where the counter equals the period value (on the way up in center mode).
- R11: Duty flag k (flag bit 1+k) is set on any counter step that starts with the counter equal to compare k.
- R12: Flags stay set until a 1 is written to their bit at address 8. A new event in the same cycle wins over the clear. The interrupt output is the OR of the flags masked by the enable register at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| pwm_o | output | 2*NPAIR | Channel outputs, even/odd per pair |
| irq_o | output | 1 | OR of enabled flags |
| flag_o | output | NPAIR+1 | Sticky flags: bit 0 period, bit 1+k duty of pair k |

## Verification
The waveform logic is driven with compare values below, equal to and above the period. Together these show the strict and non-strict comparisons and the always-low and always-high duty extremes in both counter shapes. All four prescaler codes are covered by measuring the spacing of output rising edges, which tells an off-by-one in the reload apart from a wrong step rate. Changing compare values without a load request, and loading a zero period, show whether the double buffering and the halt are honoured. Complementary runs with zero and non-zero dead-time show the added delay and the absence of overlap, and a synchronized run checks that the outputs of a pair match.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      PAIR_INDEP = 2'd0,
      PAIR_CMPL  = 2'd1,
      PAIR_SYNC  = 2'd2,
      PAIR_RSVD  = 2'd3
   } pair_mode_e;

   // control word, MSB first: bit7 invert, 6:5 mode, 4 irq-at-match,
   // 3 center, 2:1 divider code, 0 run
   typedef struct packed {
      logic       invert;
      pair_mode_e mode;
      logic       irq_at_match;
      logic       center;
      logic [1:0] div_code;
      logic       run;
   } tmr_ctrl_t;

   localparam int CTRL_W   = 8;
   localparam int LOAD_BIT = 8;

   // last prescaler count value before a step
   function automatic logic [3:0] div_limit(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd1;
         2'd2:    return 4'd3;
         default: return 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
   import pwm_pkg::*;
#(
   parameter int PW = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] code,
   output logic       tick
);

   generate
      if (PW < 4) begin : g_bad_pw
         $error("pwm_prescale: PW must hold a divide by 16");
      end
   endgenerate

   logic [PW-1:0] pc_q;
   logic [PW-1:0] lim;

   assign lim  = PW'(div_limit(code));
   assign tick = run && (pc_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pc_q <= '0;
      else if (!run || tick) pc_q <= '0;
      else                   pc_q <= pc_q + 1'b1;
   end

   // a divided step is never followed directly by another
   assert_tick_spacing_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && code != 2'd0) |=> (!tick || code == 2'd0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_pkg::*;
#(
   parameter int CW    = 16,
   parameter int NPAIR = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic                      center,
   input  logic                      load_pend,
   input  logic [CW-1:0]             stg_per,
   input  logic [NPAIR-1:0][CW-1:0]  stg_cmp,
   output logic [CW-1:0]             cnt,
   output logic [NPAIR-1:0][CW-1:0]  cmp_act,
   output logic                      apply,
   output logic                      ev_under,
   output logic                      ev_match,
   output logic [NPAIR-1:0]          ev_duty
);

   logic [CW-1:0]            cnt_q, per_q, nper;
   logic [NPAIR-1:0][CW-1:0] cmp_q;
   logic                     up_q;
   logic                     halted, at_bot, live;

   assign halted = (per_q == '0);
   assign at_bot = (cnt_q == '0) && (!center || !up_q);
   assign live   = tick && !halted;
   assign apply  = tick && load_pend && (halted || at_bot);
   assign nper   = apply ? stg_per : per_q;

   assign ev_under = live && at_bot;
   assign ev_match = live && (cnt_q == per_q) && (!center || up_q);

   generate
      for (genvar k = 0; k < NPAIR; k++) begin : g_duty
         assign ev_duty[k] = live && (cnt_q == cmp_q[k]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         cmp_q <= '0;
         up_q  <= 1'b0;
      end else if (tick) begin
         if (apply) begin
            per_q <= stg_per;
            cmp_q <= stg_cmp;
         end
         if (halted) begin
            cnt_q <= '0;
            up_q  <= 1'b0;
         end else if (at_bot) begin
            if (center) begin
               cnt_q <= (nper == '0) ? '0 : CW'(1);
               up_q  <= (nper != '0);
            end else begin
               cnt_q <= nper;
            end
         end else if (center && up_q) begin
            if (cnt_q >= per_q) begin
               up_q  <= 1'b0;
               cnt_q <= cnt_q - 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt     = cnt_q;
   assign cmp_act = cmp_q;

   assert_in_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_q);

   assert_halt_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (per_q == '0) |=> (cnt_q == '0));

   assert_no_early_load_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !load_pend |=> ($stable(per_q) && $stable(cmp_q)));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
   parameter int DTW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           src,
   input  logic [DTW-1:0] dt,
   output logic           out
);

   generate
      if (DTW < 1) begin : g_bad_dtw
         $error("pwm_deadband: DTW must be at least 1");
      end
   endgenerate

   logic [DTW:0] hold_q, hold_now;
   logic         out_q;

   // cycles the source has been high, saturating
   assign hold_now = !src ? '0 : ((&hold_q) ? hold_q : hold_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         out_q  <= 1'b0;
      end else begin
         hold_q <= hold_now;
         out_q  <= (hold_now > {1'b0, dt});
      end
   end

   assign out = out_q;

   assert_rise_needs_src_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> $past(src));

   assert_deadtime_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_q) && $past(dt) != '0) |-> $past(src, 2));

endmodule

// File: rtl/pwm_cmpl_timer.sv
module pwm_cmpl_timer
   import pwm_pkg::*;
#(
   parameter int NPAIR = 3,
   parameter int CW    = 16,
   parameter int DTW   = 8,
   parameter int AW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [CW-1:0]      wr_data,
   output logic [2*NPAIR-1:0] pwm_o,
   output logic               irq_o,
   output logic [NPAIR:0]     flag_o
);

   localparam int NCH    = 2 * NPAIR;
   localparam int A_CTRL = 0;
   localparam int A_PER  = 1;
   localparam int A_CMP  = 2;
   localparam int A_DT   = A_CMP + NPAIR;
   localparam int A_OE   = A_DT + 1;
   localparam int A_IE   = A_OE + 1;
   localparam int A_CLR  = A_IE + 1;

   generate
      if (NCH > CW || CW <= LOAD_BIT || DTW > CW || A_CLR >= (1 << AW)) begin : g_bad_cfg
         $error("pwm_cmpl_timer: inconsistent width parameters");
      end
   endgenerate

   tmr_ctrl_t                ctrl_q;
   logic [CW-1:0]            stg_per_q;
   logic [NPAIR-1:0][CW-1:0] stg_cmp_q;
   logic [DTW-1:0]           dt_q;
   logic [NCH-1:0]           oe_q;
   logic [NPAIR:0]           ie_q, flag_q, ev, clr;
   logic                     pend_q, apply, tick;
   logic                     ev_under, ev_match;
   logic [NPAIR-1:0]         ev_duty, raw;
   logic [CW-1:0]            cnt;
   logic [NPAIR-1:0][CW-1:0] cmp_act;
   logic [NCH-1:0]           ch_o;
   logic                     wr_ctrl;

   assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
   assign clr     = (wr_en && wr_addr == AW'(A_CLR)) ? wr_data[NPAIR:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         stg_per_q <= '0;
         dt_q      <= '0;
         oe_q      <= '0;
         ie_q      <= '0;
         pend_q    <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_en && wr_addr == AW'(A_PER)) stg_per_q <= wr_data;
         if (wr_en && wr_addr == AW'(A_DT))  dt_q      <= wr_data[DTW-1:0];
         if (wr_en && wr_addr == AW'(A_OE))  oe_q      <= wr_data[NCH-1:0];
         if (wr_en && wr_addr == AW'(A_IE))  ie_q      <= wr_data[NPAIR:0];
         if (apply) pend_q <= 1'b0;
         if (wr_ctrl && wr_data[LOAD_BIT]) pend_q <= 1'b1;
      end
   end

   generate
      for (genvar k = 0; k < NPAIR; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_cmp_q[k] <= '0;
            else if (wr_en && wr_addr == AW'(A_CMP + k)) stg_cmp_q[k] <= wr_data;
         end
      end
   endgenerate

   pwm_prescale #(.PW(4)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q.run),
      .code  (ctrl_q.div_code),
      .tick  (tick)
   );

   pwm_timebase #(.CW(CW), .NPAIR(NPAIR)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .center    (ctrl_q.center),
      .load_pend (pend_q),
      .stg_per   (stg_per_q),
      .stg_cmp   (stg_cmp_q),
      .cnt       (cnt),
      .cmp_act   (cmp_act),
      .apply     (apply),
      .ev_under  (ev_under),
      .ev_match  (ev_match),
      .ev_duty   (ev_duty)
   );

   // event flags: period at bit 0, duty per pair above
   assign ev = {ev_duty, (ctrl_q.irq_at_match ? ev_match : ev_under)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr) | ev;
   end

   assign flag_o = flag_q;
   assign irq_o  = |(flag_q & ie_q);

   generate
      for (genvar k = 0; k < NPAIR; k++) begin : g_pair
         assign raw[k] = ctrl_q.center ? (cnt <= cmp_act[k]) : (cnt > cmp_act[k]);

         for (genvar j = 0; j < 2; j++) begin : g_side
            logic           src;
            logic [DTW-1:0] dly;
            if (j == 1) begin : g_odd
               assign src = (ctrl_q.mode == PAIR_CMPL) ? ~raw[k] : raw[k];
            end else begin : g_even
               assign src = raw[k];
            end
            assign dly = (ctrl_q.mode == PAIR_CMPL) ? dt_q : '0;

            pwm_deadband #(.DTW(DTW)) u_db (
               .clk   (clk),
               .rst_n (rst_n),
               .src   (src),
               .dt    (dly),
               .out   (ch_o[2*k+j])
            );
         end

         assert_no_overlap_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ctrl_q.mode) == PAIR_CMPL) |-> !(ch_o[2*k] && ch_o[2*k+1]));

         assert_pair_follow_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ctrl_q.mode) != PAIR_CMPL) |-> (ch_o[2*k] == ch_o[2*k+1]));
      end

      for (genvar f = 0; f <= NPAIR; f++) begin : g_flag_chk
         assert_sticky_R12 : assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[f] && !clr[f]) |=> flag_q[f]);
         assert_w1c_R12 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr[f] && !ev[f]) |=> !flag_q[f]);
      end
   endgenerate

   assign pwm_o = oe_q & (ch_o ^ {NCH{ctrl_q.invert}});

endmodule

// File: tb/sim_pwm_cmpl_timer.sv
`timescale 1ns/1ps
module sim_pwm_cmpl_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [5:0]  pwm_o;
   logic        irq_o;
   logic [3:0]  flag_o;

   int checks = 0;
   int failures = 0;
   string tag = "R9";
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_cmpl_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .irq_o(irq_o), .flag_o(flag_o)
   );

   // ---------------- behavioural reference ----------------
   int m_run, m_div, m_cen, m_atm, m_mode, m_inv;
   int m_sper, m_dt, m_oe, m_ie, m_per, m_pend, m_cnt, m_up, m_pc, m_flags;
   int m_scmp[3];
   int m_cmp[3];
   int m_h[6];
   int m_o[6];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_run, m_div, m_cen, m_atm, m_mode, m_inv} = '{default: 0};
         {m_sper, m_dt, m_oe, m_ie, m_per, m_pend, m_cnt, m_up, m_pc, m_flags} = '{default: 0};
         for (int i = 0; i < 3; i++) begin m_scmp[i] = 0; m_cmp[i] = 0; end
         for (int i = 0; i < 6; i++) begin m_h[i] = 0; m_o[i] = 0; end
      end else begin
         int steps, ev, clrv, nper;
         bit tick, halted, bot, apply;
         steps = (m_div == 0) ? 1 : (m_div == 1) ? 2 : (m_div == 2) ? 4 : 16;
         tick = (m_run != 0) && (m_pc >= steps - 1);
         for (int k = 0; k < 3; k++) begin
            bit rw;
            rw = m_cen ? (m_cnt <= m_cmp[k]) : (m_cnt > m_cmp[k]);
            for (int j = 0; j < 2; j++) begin
               bit s;
               int d;
               s = (j == 1 && m_mode == 1) ? !rw : rw;
               d = (m_mode == 1) ? m_dt : 0;
               m_h[2*k+j] = s ? ((m_h[2*k+j] < 511) ? m_h[2*k+j] + 1 : 511) : 0;
               m_o[2*k+j] = (m_h[2*k+j] > d) ? 1 : 0;
            end
         end
         halted = (m_per == 0);
         bot = (m_cnt == 0) && (!m_cen || !m_up);
         ev = 0;
         if (tick && !halted) begin
            if (m_atm ? (m_cnt == m_per && (!m_cen || m_up)) : bot) ev |= 1;
            for (int k = 0; k < 3; k++) if (m_cnt == m_cmp[k]) ev |= (2 << k);
         end
         clrv = (wr_en && wr_addr == 8) ? int'(wr_data) : 0;
         m_flags = (m_flags & ~clrv & 15) | ev;
         apply = tick && (m_pend != 0) && (halted || bot);
         nper = apply ? m_sper : m_per;
         if (tick) begin
            if (halted) begin m_cnt = 0; m_up = 0; end
            else if (bot) begin
               if (m_cen) begin m_cnt = (nper != 0) ? 1 : 0; m_up = (nper != 0); end
               else m_cnt = nper;
            end else if (m_cen && m_up) begin
               if (m_cnt >= m_per) begin m_up = 0; m_cnt--; end else m_cnt++;
            end else m_cnt--;
         end
         if (apply) begin
            m_per = m_sper;
            for (int k = 0; k < 3; k++) m_cmp[k] = m_scmp[k];
            m_pend = 0;
         end
         if (!m_run || tick) m_pc = 0; else m_pc++;
         if (wr_en) begin
            case (wr_addr)
               0: begin
                  m_run = wr_data[0]; m_div = wr_data[2:1]; m_cen = wr_data[3];
                  m_atm = wr_data[4]; m_mode = wr_data[6:5]; m_inv = wr_data[7];
                  if (wr_data[8]) m_pend = 1;
               end
               1: m_sper = wr_data;
               2, 3, 4: m_scmp[wr_addr-2] = wr_data;
               5: m_dt = wr_data[7:0];
               6: m_oe = wr_data[5:0];
               7: m_ie = wr_data[3:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [5:0] exp_pwm();
      logic [5:0] r;
      for (int c = 0; c < 6; c++) r[c] = m_oe[c] & (m_o[c][0] ^ m_inv[0]);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [5:0] ep;
         ep = exp_pwm();
         check(pwm_o == ep, tag, "pwm", pwm_o, ep);
         check(flag_o == m_flags[3:0], tag, "flags", flag_o, m_flags);
         check(irq_o == |(m_flags[3:0] & m_ie[3:0]), tag, "irq", irq_o,
               |(m_flags[3:0] & m_ie[3:0]));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int cw(int run, int dv, int cen, int atm, int mode, int inv, int ld);
      return run | (dv << 1) | (cen << 3) | (atm << 4) | (mode << 5) | (inv << 7) | (ld << 8);
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // cycles between two rising edges of channel 0
   task automatic rise_gap(output int gap);
      logic p;
      int guard;
      gap = 0; guard = 0;
      p = pwm_o[0];
      @(negedge clk);
      while (!(pwm_o[0] && !p) && guard < 2000) begin p = pwm_o[0]; @(negedge clk); guard++; end
      p = pwm_o[0];
      @(negedge clk); gap = 1;
      while (!(pwm_o[0] && !p) && guard < 4000) begin p = pwm_o[0]; @(negedge clk); gap++; guard++; end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired during %s", tag);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int g;
      idle(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(pwm_o == 0 && irq_o == 0 && flag_o == 0, "R9", "reset state",
            {pwm_o, irq_o, flag_o}, 0);

      // R4/R5: staged values, counter running but period still 0
      tag = "R4";
      wr(1, 9); wr(2, 3); wr(3, 0); wr(4, 9);
      wr(6, 'h3F); wr(7, 'hF);
      wr(0, cw(1, 0, 0, 0, 0, 0, 0));
      idle(30);
      check(flag_o == 0 && pwm_o == 0, "R5", "halted without load", {pwm_o, flag_o}, 0);

      // R6/R11: edge-aligned, compare below, at 0 and equal to period
      tag = "R6";
      wr(0, cw(1, 0, 0, 0, 0, 0, 1));
      idle(60);
      tag = "R11";
      idle(20);

      // R4: compare change without load, then with load
      tag = "R4";
      wr(2, 7);
      idle(25);
      wr(0, cw(1, 0, 0, 0, 0, 0, 1));
      idle(40);

      // R12: stop, clear, observe
      tag = "R12";
      wr(0, cw(0, 0, 0, 0, 0, 0, 0));
      wr(8, 'hF);
      idle(2);
      check(flag_o == 0 && irq_o == 0, "R12", "cleared flags", {flag_o, irq_o}, 0);
      wr(7, 'h2);
      wr(0, cw(1, 0, 0, 0, 0, 0, 0));
      idle(30);
      check(flag_o[1] && irq_o, "R12", "duty flag reasserts irq", {flag_o, irq_o}, 'h3);

      // R1/R2: divide by 16, period 3 -> 64 cycles per waveform
      tag = "R1";
      wr(1, 3); wr(2, 1);
      wr(0, cw(1, 3, 0, 0, 0, 0, 1));
      idle(200);
      rise_gap(g);
      check(g == 64, "R1", "edge period div16", g, 64);
      wr(0, cw(1, 2, 0, 0, 0, 0, 0));
      idle(80);
      rise_gap(g);
      check(g == 16, "R2", "edge period div4", g, 16);

      // R3: center, period 4, divide by 2 -> 16 cycles
      tag = "R3";
      wr(1, 4); wr(2, 2);
      wr(0, cw(1, 1, 1, 0, 0, 0, 1));
      idle(100);
      rise_gap(g);
      check(g == 16, "R3", "center period div2", g, 16);

      // R8: complementary with dead-time 3, then 0
      tag = "R8";
      wr(1, 6); wr(2, 2); wr(3, 4); wr(4, 0); wr(5, 3);
      wr(0, cw(1, 0, 1, 0, 1, 0, 1));
      idle(10);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         for (int k = 0; k < 3; k++)
            check(!(pwm_o[2*k] && pwm_o[2*k+1]), "R8", "pair overlap", pwm_o, 0);
      end
      wr(5, 0);
      idle(40);

      // R10: period flag at period match, only that flag enabled
      tag = "R10";
      wr(7, 'h1); wr(8, 'hF);
      wr(1, 5); wr(2, 2);
      wr(0, cw(1, 0, 0, 1, 0, 0, 1));
      idle(60);
      wr(0, cw(1, 1, 1, 1, 0, 0, 1));
      idle(60);

      // R9: inverter and partial enables
      tag = "R9";
      wr(6, 'h15);
      wr(0, cw(1, 0, 0, 0, 0, 1, 1));
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(pwm_o[1] == 0 && pwm_o[3] == 0 && pwm_o[5] == 0, "R9", "disabled outputs",
               pwm_o, pwm_o & 6'h15);
      end

      // R7: synchronized pairs ignore dead-time
      tag = "R7";
      wr(6, 'h3F); wr(5, 5); wr(1, 7); wr(2, 3); wr(3, 8);
      wr(0, cw(1, 0, 0, 0, 2, 0, 1));
      idle(10);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         check(pwm_o[0] == pwm_o[1] && pwm_o[2] == pwm_o[3], "R7", "pair match", pwm_o, 0);
      end

      // R5: load a zero period, counter halts, outputs frozen
      tag = "R5";
      wr(1, 0);
      wr(0, cw(1, 0, 0, 0, 0, 0, 1));
      idle(30);
      begin
         logic [5:0] held;
         held = pwm_o;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(pwm_o == held, "R5", "halted output", pwm_o, held);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule